// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers the four level-sensitive PCI interrupt pins (A, B, C and D) onto sixteen ISA interrupt request lines. Software sets the steering through three byte-wide configuration registers at addresses 0x55, 0x56 and 0x57. It writes them through a simple strobe-qualified write port and can read them back through a combinational read port that uses the same address bus.

Each pin takes a 4-bit routing code, and the code is the number of the ISA line that the pin drives. The codes 0 and 15 turn the pin off. Code 2 is reserved: a pin with code 2 drives nothing, and when that pin is asserted it sets a sticky error flag. Software clears the flag with a write-one-to-clear strobe. Several pins may share one line, and that line then carries the OR of their levels. The ISA outputs are registered.

Top module: `pirq_router`

## Requirements
- R1: While reset is active and right after it, all three configuration bytes read 0x00, every ISA output is low and the error flag is low.
- R2: A write with `cfg_wr_en` high to address 0x55, 0x56 or 0x57 stores `cfg_wdata` on the clock edge, and `cfg_rdata` returns the stored byte for that address. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R3: The pin codes sit at fixed nibble positions. Pin A uses bits [7:4] of 0x55. Pin B uses bits [3:0] of 0x56. Pin C uses bits [7:4] of 0x56. Pin D uses bits [7:4] of 0x57. An asserted pin with a code from 1 to 14 other than 2 drives ISA line `isa_irq[code]`.
- R4: Bits [3:0] of 0x55 and bits [3:0] of 0x57 are stored and can be read back, but they have no effect on any output.
- R5: A pin with code 0 or 15 drives no ISA line.
- R6: A pin with code 2 drives no ISA line. While that pin is asserted, `route_err` is set.
- R7: Each ISA line is the OR of all asserted pins whose code selects it. When no pin is asserted, all lines are low one cycle later.
- R8: `isa_irq[0]`, `isa_irq[2]` and `isa_irq[15]` are low at all times.
- R9: A change of pin level shows on `isa_irq` one clock after it is sampled. A configuration write shows on `isa_irq` two clocks after the write is sampled.
- R10: `route_err` stays set until it is cleared. A cycle with `err_clr` high clears it, unless a new error occurs in the same cycle, in which case the flag stays set.
- R11: When an asserted pin is moved to a new line, the old line falls in the same cycle that the new line rises, unless another asserted pin still holds the old line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration address, used for both writes and reads |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored byte at `cfg_addr`, or 0x00 |
| pci_int | input | 4 | PCI pin levels, bit 0 = A to bit 3 = D, high = asserted |
| err_clr | input | 1 | Write-one-to-clear for `route_err` |
| isa_irq | output | 16 | Registered ISA request lines |
| route_err | output | 1 | Sticky flag for an asserted pin with reserved code 2 |

## Verification
The bench asserts each pin on its own, which shows whether every pin reads its own nibble. It also steps one pin through all sixteen codes, which separates valid codes from the disabled, reserved and always-low lines. Cases where two pins share a line and drop out one at a time show whether the line is an OR or is overwritten. Moving a pin to a new line while it is asserted, with and without a second pin on the old line, checks when the old line falls. Error set and clear in the same cycle fixes the priority of the flag.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int NUM_PINS = 4;
    localparam int NUM_IRQ  = 16;
    localparam int DATA_W   = 8;
    localparam int CODE_W   = $clog2(NUM_IRQ);
    localparam int RSV_CODE = 2;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [NUM_IRQ-1:0] isa;
        logic               err;
    } rtr_state_t;
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] BASE = 'h55,
    parameter int NBYTES = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output logic [NBYTES-1:0][DATA_W-1:0]  bytes_o
);
    logic [NBYTES-1:0][DATA_W-1:0] bytes_d, bytes_q;
    logic [NBYTES-1:0]             hit;

    // One address comparator per stored byte
    for (genvar g = 0; g < NBYTES; g++) begin : g_hit
        assign hit[g] = (addr == BASE + ADDR_W'(g));
    end

    always_comb begin
        bytes_d = bytes_q;
        rdata   = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (hit[i]) begin
                rdata = bytes_q[i];
                if (wr_en) bytes_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bytes_q <= '0;
        else        bytes_q <= bytes_d;
    end

    assign bytes_o = bytes_q;
endmodule

// File: rtl/pirq_decode.sv
module pirq_decode #(
    parameter int NUM_IRQ  = 16,
    parameter int CODE_W   = $clog2(NUM_IRQ),
    parameter int RSV_CODE = 2
) (
    input  logic [CODE_W-1:0]  code,
    output logic [NUM_IRQ-1:0] sel,
    output logic               reserved
);
    localparam logic [CODE_W-1:0] OFF_LO = '0;
    localparam logic [CODE_W-1:0] OFF_HI = CODE_W'(NUM_IRQ - 1);
    localparam logic [CODE_W-1:0] RSV    = CODE_W'(RSV_CODE);

    always_comb begin
        sel      = '0;
        reserved = (code == RSV);
        if (code != OFF_LO && code != OFF_HI && code != RSV)
            sel[code] = 1'b1;
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CFG_BASE = 'h55
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr_en,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    input  logic [NUM_PINS-1:0] pci_int,
    input  logic               err_clr,
    output logic [NUM_IRQ-1:0] isa_irq,
    output logic               route_err
);
    localparam int CFG_BYTES = 3;
    // Lines that no code may ever drive
    localparam logic [NUM_IRQ-1:0] LOW_MASK =
        (NUM_IRQ'(1) << 0) | (NUM_IRQ'(1) << RSV_CODE) | (NUM_IRQ'(1) << (NUM_IRQ - 1));

    logic [CFG_BYTES-1:0][DATA_W-1:0] cfg_bytes;
    code_t [NUM_PINS-1:0]             pin_code;
    logic  [NUM_PINS-1:0][NUM_IRQ-1:0] pin_sel;
    logic  [NUM_PINS-1:0]             pin_rsv;
    rtr_state_t                       st_d, st_q;

    pirq_cfg_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BASE   (CFG_BASE),
        .NBYTES (CFG_BYTES)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .bytes_o (cfg_bytes)
    );

    // Fixed nibble positions: A=0x55 hi, B=0x56 lo, C=0x56 hi, D=0x57 hi
    assign pin_code[0] = cfg_bytes[0][7:4];
    assign pin_code[1] = cfg_bytes[1][3:0];
    assign pin_code[2] = cfg_bytes[1][7:4];
    assign pin_code[3] = cfg_bytes[2][7:4];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pirq_decode #(
            .NUM_IRQ  (NUM_IRQ),
            .CODE_W   (CODE_W),
            .RSV_CODE (RSV_CODE)
        ) u_dec (
            .code     (pin_code[p]),
            .sel      (pin_sel[p]),
            .reserved (pin_rsv[p])
        );
    end

    always_comb begin
        st_d.isa = '0;
        st_d.err = st_q.err & ~err_clr;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (pci_int[p]) begin
                st_d.isa = st_d.isa | pin_sel[p];
                if (pin_rsv[p]) st_d.err = 1'b1;
            end
        end
        st_d.isa = st_d.isa & ~LOW_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isa_irq   = st_q.isa;
    assign route_err = st_q.err;
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  pci_int,
    input logic        err_clr,
    input logic [15:0] isa_irq,
    input logic        route_err
);
    a_r8_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
        !(isa_irq[0] || isa_irq[2] || isa_irq[15]));

    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_int == 4'b0) |=> (isa_irq == 16'h0));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (route_err && !err_clr) |=> route_err);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && pci_int == 4'b0) |=> !route_err);

    a_r6_err_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!route_err && pci_int == 4'b0) |=> !route_err);
endmodule

bind pirq_router pirq_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pci_int   (pci_int),
    .err_clr   (err_clr),
    .isa_irq   (isa_irq),
    .route_err (route_err)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_addr = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic [3:0]  pci_int = 4'h0;
    logic        err_clr = 1'b0;
    logic [15:0] isa_irq;
    logic        route_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state
    logic [7:0]  m_cfg [3];
    logic [15:0] m_isa = '0;
    logic        m_err = 1'b0;

    pirq_router u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_wr_en (cfg_wr_en), .cfg_addr (cfg_addr),
        .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata), .pci_int (pci_int),
        .err_clr (err_clr), .isa_irq (isa_irq), .route_err (route_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int code_of(int pin);
        case (pin)
            0: return int'(m_cfg[0][7:4]);
            1: return int'(m_cfg[1][3:0]);
            2: return int'(m_cfg[1][7:4]);
            default: return int'(m_cfg[2][7:4]);
        endcase
    endfunction

    function automatic logic [7:0] model_read(logic [7:0] a);
        if (a >= 8'h55 && a <= 8'h57) return m_cfg[a - 8'h55];
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle model and per-cycle comparison
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) m_cfg[i] = 8'h00;
            m_isa = '0;
            m_err = 1'b0;
        end else begin
            logic [15:0] nx;
            logic        ne;
            nx = '0;
            ne = m_err && !err_clr;
            for (int p = 0; p < 4; p++) begin
                if (pci_int[p]) begin
                    int c;
                    c = code_of(p);
                    if (c == 2) ne = 1'b1;
                    else if (c != 0 && c != 15) nx[c] = 1'b1;
                end
            end
            m_isa = nx;
            m_err = ne;
            if (cfg_wr_en && cfg_addr >= 8'h55 && cfg_addr <= 8'h57)
                m_cfg[cfg_addr - 8'h55] = cfg_wdata;
        end
        #(CLK_PERIOD/4);
        if (!done) begin
            check("R7/R9 isa_irq vs model", 32'(isa_irq), 32'(m_isa));
            check("R10 route_err vs model", 32'(route_err), 32'(m_err));
            check("R2 cfg_rdata vs model", 32'(cfg_rdata), 32'(model_read(cfg_addr)));
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic pins(logic [3:0] v);
        @(negedge clk);
        pci_int = v;
    endtask

    // Wait until the next edge has been absorbed
    task automatic settle();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic rd_check(string tag, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(tag, 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 isa in reset", 32'(isa_irq), 0);
        check("R1 err in reset", 32'(route_err), 0);
        rst_n = 1'b1;
        settle();
        check("R1 isa after reset", 32'(isa_irq), 0);
        rd_check("R1 byte 0x55", 8'h55, 8'h00);
        rd_check("R1 byte 0x57", 8'h57, 8'h00);

        // R2: writes and reads
        wr(8'h55, 8'h5A);
        wr(8'h56, 8'h93);
        wr(8'h57, 8'hC7);
        wr(8'h40, 8'hFF);
        wr(8'h58, 8'hFF);
        rd_check("R2 readback 0x55", 8'h55, 8'h5A);
        rd_check("R2 readback 0x56", 8'h56, 8'h93);
        rd_check("R2 readback 0x57", 8'h57, 8'hC7);
        rd_check("R2 other address reads zero", 8'h40, 8'h00);
        rd_check("R2 0x58 reads zero", 8'h58, 8'h00);

        // R3 and R9: each pin on its own
        pins(4'b0001);
        #1 check("R9 not before edge", 32'(isa_irq), 0);
        settle();
        check("R3 R9 pin A to line 5", 32'(isa_irq), 32'h0020);
        pins(4'b0010); settle();
        check("R3 pin B to line 3", 32'(isa_irq), 32'h0008);
        pins(4'b0100); settle();
        check("R3 pin C to line 9", 32'(isa_irq), 32'h0200);
        pins(4'b1000); settle();
        check("R3 pin D to line 12", 32'(isa_irq), 32'h1000);

        // R4: lower nibbles of 0x55 and 0x57 do nothing
        pins(4'b1001);
        wr(8'h55, 8'h53);
        wr(8'h57, 8'hC5);
        settle();
        check("R4 low nibbles ignored", 32'(isa_irq), 32'h1020);
        rd_check("R4 low nibble stored", 8'h57, 8'hC5);

        // R5: disabled codes 0 and 15
        wr(8'h57, 8'h00); settle();
        check("R5 code 0 disables D", 32'(isa_irq), 32'h0020);
        wr(8'h57, 8'hF0); settle();
        check("R5 code 15 disables D", 32'(isa_irq), 32'h0020);

        // R7: shared line is an OR
        wr(8'h56, 8'h95);
        pins(4'b0011); settle();
        check("R7 A and B share line 5", 32'(isa_irq), 32'h0020);
        pins(4'b0010); settle();
        check("R7 B alone holds line 5", 32'(isa_irq), 32'h0020);
        pins(4'b0000); settle();
        check("R7 no pins, line low", 32'(isa_irq), 32'h0000);

        // R6 and R10: reserved code and sticky flag
        wr(8'h56, 8'h92);
        pins(4'b0010); settle();
        check("R6 code 2 drives nothing", 32'(isa_irq), 32'h0000);
        check("R6 error raised", 32'(route_err), 1);
        pins(4'b0000); settle(); settle();
        check("R10 error sticky", 32'(route_err), 1);
        @(negedge clk); err_clr = 1'b1; pci_int = 4'b0010;
        @(negedge clk); err_clr = 1'b0; pci_int = 4'b0000;
        #1 check("R10 set wins over clear", 32'(route_err), 1);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        #1 check("R10 cleared by strobe", 32'(route_err), 0);

        // R8: sweep all codes on pin A
        pins(4'b0001);
        for (int c = 0; c < 16; c++) begin
            wr(8'h55, 8'(c << 4));
            settle();
            check("R8 lines 0 2 15 low", 32'({isa_irq[15], isa_irq[2], isa_irq[0]}), 0);
            check("R3 sweep line", 32'(isa_irq),
                  (c == 0 || c == 2 || c == 15) ? 32'h0 : (32'h1 << c));
        end
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;

        // R11: reroute while asserted
        wr(8'h55, 8'h50);
        wr(8'h56, 8'h90);
        pins(4'b0101); settle();
        check("R11 start A on 5, C on 9", 32'(isa_irq), 32'h0220);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_addr = 8'h55; cfg_wdata = 8'h70;
        @(posedge clk); #(CLK_PERIOD/4);
        cfg_wr_en = 1'b0;
        check("R11 no move one edge after write", 32'(isa_irq), 32'h0220);
        settle();
        check("R11 5 falls as 7 rises", 32'(isa_irq), 32'h0280);
        wr(8'h55, 8'h90); settle();
        check("R11 C still holds 9", 32'(isa_irq), 32'h0200);

        pins(4'b0000);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule